// File: doc/BRIEF.md
# Touch Panel Plate Driver and SAR Conversion Sequencer

This block sits between a register write/read port and the analog front end of a four-terminal resistive touch panel. One control register chooses which panel terminals are switched to the supply and which are switched to ground, enables the bias drive and picks the measurement configuration. When a terminal is asked to be both powered and grounded, the hardware grounds it and leaves its supply switch open, so no register value can short the supply. A touch-detect configuration grounds the Y plate and connects the X plate to a passive pull-up.

A second control register picks one of eight analog multiplexer inputs and starts a 10-bit successive-approximation conversion. The start is either immediate, or it arms the block so that the next rising edge on an external sync pin begins the conversion. The sequencer tests one bit per clock, from the most significant bit down, against an external comparator. It then stores the code, raises a ready flag and gives a one-cycle completion pulse to the interrupt logic. A third address reads back the ready flag and the result.

Top module: `tsc_adc_seq`

## Requirements
- R1: After a synchronous reset, every switch output, the bias, the pull-up, the mode, the multiplexer select, the ready flag, the completion pulse and the read data are all 0.
- R2: In the touch control register (address 0x64), bits [3:0] request the supply switch and bits [7:4] request the ground switch for terminals 0=X+, 1=X-, 2=Y+, 3=Y-. A terminal with both requests set is grounded and its supply output stays 0. The outputs follow a write one clock after it.
- R3: Mode field bits [10:9] encode 00 position, 01 pressure, 10 plate resistance, 11 touch detect. In the first three modes the bias output follows bit [8], the supply and ground outputs follow R2, and the pull-up is 0.
- R4: In touch-detect mode both Y terminals are grounded, whatever their bits. No supply switch is closed, the bias is off and the X pull-up output is 1.
- R5: In the ADC control register (address 0x66), bits [2:0] drive the multiplexer select: 0 X+, 1 X-, 2 Y+, 3 Y-, 4 to 7 auxiliary inputs 0 to 3.
- R6: Writing the ADC control register with bit [4]=1 and bit [3]=0 starts a conversion at that clock edge. The ready flag is 0 from the next cycle on, and it returns to 1 ten clock edges after the start.
- R7: The sequencer tries bits from 9 down to 0, one per clock. A trial bit is kept when the comparator input is 0 (the trial value is not above the input) and dropped when it is 1, so the stored code is the largest value not above the input.
- R8: A read of address 0x68 returns, one clock later, the ready flag in bit 15 and the result in bits [9:0], with the other bits 0.
- R9: A write with bits [4] and [3] both 1 arms the block without starting it and leaves the ready flag unchanged. The first rising edge of the sync input after the arm, after a two-stage synchronizer, starts the conversion. A sync edge with nothing armed starts nothing.
- R10: A start or arm request that arrives while a conversion is running, including on its final edge, is ignored. The running conversion finishes on its original schedule, and no second conversion follows.
- R11: The completion output is a pulse of exactly one cycle. It is high in the first cycle that the ready flag is 1 after a conversion.
- R12: Reading 0x64 returns the stored touch control bits [10:0]. Reading 0x66 returns the select in [2:0] and the sync-mode bit in [3], with the start bit reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the conversion steps once per edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 7 | Register read address |
| rd_data | output | 16 | Registered read data |
| adc_sync | input | 1 | External conversion sync, asynchronous |
| cmp_hi | input | 1 | Comparator: 1 when the trial value is above the input |
| plate_pwr_o | output | 4 | Supply switch per panel terminal |
| plate_gnd_o | output | 4 | Ground switch per panel terminal |
| bias_en_o | output | 1 | Bias drive enable |
| x_pullup_o | output | 1 | Passive pull-up on the X plate |
| meas_mode_o | output | 2 | Current measurement mode |
| mux_sel_o | output | 3 | Analog multiplexer select |
| dac_trial_o | output | 10 | Trial value presented to the comparator |
| adc_ready_o | output | 1 | Result-valid flag |
| conv_done_o | output | 1 | One-cycle completion pulse for the interrupt logic |

## Verification
Two functions can meet in a single edge: a new start request and the final bit decision of the conversion in flight. The bench provokes this by timing a start write so that the same edge samples it as the one that stores bit 0. The bench then expects the ready flag to rise and stay high with a single completion pulse, and no restart one cycle later. A second collision, a start in the middle of the run, must leave the ten-edge schedule and the stored code unchanged. The bench judges this against a comparator model driven by the value it chose for the selected input.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  // terminal indices on the plate switch vectors
  localparam int NUM_TERM  = 4;
  localparam int TERM_XP   = 0;
  localparam int TERM_XM   = 1;
  localparam int TERM_YP   = 2;
  localparam int TERM_YM   = 3;

  // touch control register layout
  localparam int TC_PWR_LSB  = 0;
  localparam int TC_GND_LSB  = 4;
  localparam int TC_BIAS_BIT = 8;
  localparam int TC_MODE_LSB = 9;
  localparam int TC_W        = 11;

  // ADC control register layout
  localparam int AC_SEL_LSB  = 0;
  localparam int AC_SEL_W    = 3;
  localparam int AC_SYNC_BIT = 3;
  localparam int AC_GO_BIT   = 4;

  // data register layout
  localparam int DR_READY_BIT = 15;

  typedef enum logic [1:0] {
    MODE_POS    = 2'b00,
    MODE_PRES   = 2'b01,
    MODE_RES    = 2'b10,
    MODE_DETECT = 2'b11
  } tsc_mode_e;
endpackage

// File: rtl/tsc_plate_drive.sv
module tsc_plate_drive
  import tsc_pkg::*;
#(
  parameter int NT = NUM_TERM
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NT-1:0] pwr_req,
  input  logic [NT-1:0] gnd_req,
  input  logic          bias_req,
  input  tsc_mode_e     mode,
  output logic [NT-1:0] pwr_o,
  output logic [NT-1:0] gnd_o,
  output logic          bias_o,
  output logic          pullup_o,
  output logic [1:0]    mode_o
);
  logic detect;
  assign detect = (mode == MODE_DETECT);

  for (genvar t = 0; t < NT; t++) begin : g_term
    localparam bit IS_Y = (t == TERM_YP) || (t == TERM_YM);
    logic pwr_q, gnd_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        pwr_q <= 1'b0;
        gnd_q <= 1'b0;
      end else if (detect) begin
        pwr_q <= 1'b0;
        gnd_q <= gnd_req[t] | IS_Y;
      end else begin
        // ground wins over supply on a conflicting request
        pwr_q <= pwr_req[t] & ~gnd_req[t];
        gnd_q <= gnd_req[t];
      end
    end
    assign pwr_o[t] = pwr_q;
    assign gnd_o[t] = gnd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bias_o   <= 1'b0;
      pullup_o <= 1'b0;
      mode_o   <= 2'b00;
    end else begin
      bias_o   <= bias_req & ~detect;
      pullup_o <= detect;
      mode_o   <= mode;
    end
  end
endmodule

// File: rtl/tsc_start_ctrl.sv
module tsc_start_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic sync_mode,
  input  logic sync_in,
  input  logic busy,
  output logic launch
);
  logic [SYNC_STAGES-1:0] sync_sr;
  logic sync_last;
  logic armed;
  logic sync_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_sr   <= '0;
      sync_last <= 1'b0;
    end else begin
      sync_sr   <= {sync_sr[SYNC_STAGES-2:0], sync_in};
      sync_last <= sync_sr[SYNC_STAGES-1];
    end
  end

  assign sync_rise = sync_sr[SYNC_STAGES-1] & ~sync_last;

  assign launch = ~busy & ((start_req & ~sync_mode) | (armed & sync_rise));

  always_ff @(posedge clk) begin
    if (rst)
      armed <= 1'b0;
    else if (launch)
      armed <= 1'b0;
    else if (start_req && sync_mode && !busy)
      armed <= 1'b1;
  end
endmodule

// File: rtl/tsc_sar_core.sv
module tsc_sar_core #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         launch,
  input  logic         cmp_hi,
  output logic [W-1:0] trial_o,
  output logic         busy_o,
  output logic [W-1:0] result_o,
  output logic         ready_o,
  output logic         done_o
);
  logic [W-1:0] acc_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] acc_next;

  assign trial_o  = acc_q | mask_q;
  assign acc_next = cmp_hi ? acc_q : (acc_q | mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      mask_q   <= '0;
      busy_o   <= 1'b0;
      result_o <= '0;
      ready_o  <= 1'b0;
      done_o   <= 1'b0;
    end else if (launch) begin
      acc_q   <= '0;
      mask_q  <= {1'b1, {(W-1){1'b0}}};
      busy_o  <= 1'b1;
      ready_o <= 1'b0;
      done_o  <= 1'b0;
    end else if (busy_o) begin
      acc_q  <= acc_next;
      mask_q <= mask_q >> 1;
      if (mask_q[0]) begin
        busy_o   <= 1'b0;
        result_o <= acc_next;
        ready_o  <= 1'b1;
        done_o   <= 1'b1;
      end
    end else begin
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tsc_adc_seq.sv
module tsc_adc_seq
  import tsc_pkg::*;
#(
  parameter int          ADDR_W      = 7,
  parameter int          DATA_W      = 16,
  parameter int          RES_W       = 10,
  parameter int          SYNC_STAGES = 2,
  parameter logic [6:0]  ADDR_TOUCH  = 7'h64,
  parameter logic [6:0]  ADDR_ADC    = 7'h66,
  parameter logic [6:0]  ADDR_DATA   = 7'h68
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                adc_sync,
  input  logic                cmp_hi,
  output logic [NUM_TERM-1:0] plate_pwr_o,
  output logic [NUM_TERM-1:0] plate_gnd_o,
  output logic                bias_en_o,
  output logic                x_pullup_o,
  output logic [1:0]          meas_mode_o,
  output logic [AC_SEL_W-1:0] mux_sel_o,
  output logic [RES_W-1:0]    dac_trial_o,
  output logic                adc_ready_o,
  output logic                conv_done_o
);
  localparam int PAD_TC  = DATA_W - TC_W;
  localparam int PAD_AC  = DATA_W - AC_SEL_W - 2;
  localparam int PAD_DR  = DATA_W - 1 - RES_W;

  logic [TC_W-1:0]     touch_q;
  logic [AC_SEL_W-1:0] sel_q;
  logic                sync_mode_q;
  logic                wr_touch, wr_adc, start_req, launch;
  logic                sar_busy;
  logic [RES_W-1:0]    sar_result;
  logic                unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:TC_W];

  assign wr_touch  = wr_en && (wr_addr == ADDR_TOUCH);
  assign wr_adc    = wr_en && (wr_addr == ADDR_ADC);
  assign start_req = wr_adc && wr_data[AC_GO_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      touch_q     <= '0;
      sel_q       <= '0;
      sync_mode_q <= 1'b0;
    end else begin
      if (wr_touch) touch_q <= wr_data[TC_W-1:0];
      if (wr_adc) begin
        sel_q       <= wr_data[AC_SEL_LSB +: AC_SEL_W];
        sync_mode_q <= wr_data[AC_SYNC_BIT];
      end
    end
  end

  assign mux_sel_o = sel_q;

  tsc_plate_drive #(.NT(NUM_TERM)) u_plate (
    .clk      (clk),
    .rst      (rst),
    .pwr_req  (touch_q[TC_PWR_LSB +: NUM_TERM]),
    .gnd_req  (touch_q[TC_GND_LSB +: NUM_TERM]),
    .bias_req (touch_q[TC_BIAS_BIT]),
    .mode     (tsc_mode_e'(touch_q[TC_MODE_LSB +: 2])),
    .pwr_o    (plate_pwr_o),
    .gnd_o    (plate_gnd_o),
    .bias_o   (bias_en_o),
    .pullup_o (x_pullup_o),
    .mode_o   (meas_mode_o)
  );

  tsc_start_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_start (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .sync_mode (wr_data[AC_SYNC_BIT]),
    .sync_in   (adc_sync),
    .busy      (sar_busy),
    .launch    (launch)
  );

  tsc_sar_core #(.W(RES_W)) u_sar (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .cmp_hi   (cmp_hi),
    .trial_o  (dac_trial_o),
    .busy_o   (sar_busy),
    .result_o (sar_result),
    .ready_o  (adc_ready_o),
    .done_o   (conv_done_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (rd_addr)
        ADDR_TOUCH: rd_data <= {{PAD_TC{1'b0}}, touch_q};
        ADDR_ADC:   rd_data <= {{PAD_AC{1'b0}}, 1'b0, sync_mode_q, sel_q};
        ADDR_DATA:  rd_data <= {adc_ready_o, {PAD_DR{1'b0}}, sar_result};
        default:    rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tsc_adc_seq_chk.sv
module tsc_adc_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] plate_pwr_o,
  input logic [3:0] plate_gnd_o,
  input logic       bias_en_o,
  input logic       x_pullup_o,
  input logic [1:0] meas_mode_o,
  input logic       adc_ready_o,
  input logic       conv_done_o,
  input logic       sar_busy
);
  // R2: no terminal is powered and grounded at once
  assert_no_short_R2: assert property (@(posedge clk) disable iff (rst)
    (plate_pwr_o & plate_gnd_o) == 4'b0000);

  // R4: detect mode configuration
  assert_detect_cfg_R4: assert property (@(posedge clk) disable iff (rst)
    (meas_mode_o == 2'b11) |-> (x_pullup_o && plate_gnd_o[3:2] == 2'b11 &&
                                plate_pwr_o == 4'b0000 && !bias_en_o));

  // R6: ready stays low while the sequencer runs
  assert_ready_low_busy_R6: assert property (@(posedge clk) disable iff (rst)
    sar_busy |-> !adc_ready_o);

  // R11: completion pulse is one cycle and coincides with ready
  assert_done_ready_R11: assert property (@(posedge clk) disable iff (rst)
    conv_done_o |-> adc_ready_o);
  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    conv_done_o |=> !conv_done_o);

  // R10: ready only rises through a completed conversion
  assert_ready_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_ready_o) |-> conv_done_o);
endmodule

bind tsc_adc_seq tsc_adc_seq_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .plate_pwr_o (plate_pwr_o),
  .plate_gnd_o (plate_gnd_o),
  .bias_en_o   (bias_en_o),
  .x_pullup_o  (x_pullup_o),
  .meas_mode_o (meas_mode_o),
  .adc_ready_o (adc_ready_o),
  .conv_done_o (conv_done_o),
  .sar_busy    (sar_busy)
);

// File: tb/test_tsc_adc_seq.sv
module test_tsc_adc_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] A_TC = 7'h64;
  localparam logic [6:0] A_AC = 7'h66;
  localparam logic [6:0] A_DR = 7'h68;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [6:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        adc_sync = 1'b0;
  logic        cmp_hi;
  logic [3:0]  plate_pwr_o, plate_gnd_o;
  logic        bias_en_o, x_pullup_o;
  logic [1:0]  meas_mode_o;
  logic [2:0]  mux_sel_o;
  logic [9:0]  dac_trial_o;
  logic        adc_ready_o, conv_done_o;

  logic [9:0]  vin [8];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // comparator model: high when the trial value is above the selected input
  assign cmp_hi = dac_trial_o > vin[mux_sel_o];

  tsc_adc_seq i_tsc_adc_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .adc_sync(adc_sync), .cmp_hi(cmp_hi),
    .plate_pwr_o(plate_pwr_o), .plate_gnd_o(plate_gnd_o), .bias_en_o(bias_en_o),
    .x_pullup_o(x_pullup_o), .meas_mode_o(meas_mode_o), .mux_sel_o(mux_sel_o),
    .dac_trial_o(dac_trial_o), .adc_ready_o(adc_ready_o), .conv_done_o(conv_done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  // expected {mode, pullup, bias, gnd, pwr} for a touch control value
  function automatic logic [11:0] exp_plate(input logic [10:0] v);
    logic [3:0] p, g;
    logic [1:0] m;
    m = v[10:9]; p = v[3:0]; g = v[7:4];
    if (m == 2'b11) return {m, 1'b1, 1'b0, g | 4'b1100, 4'b0000};
    return {m, 1'b0, v[8], g, p & ~g};
  endfunction

  task automatic plate_case(input logic [10:0] v, input string req);
    wr(A_TC, {5'b0, v});
    @(negedge clk);
    chk(req, {meas_mode_o, x_pullup_o, bias_en_o, plate_gnd_o, plate_pwr_o}, exp_plate(v));
  endtask

  task automatic direct_conv(input logic [2:0] ch, input logic [9:0] val);
    logic [15:0] d;
    vin[ch] = val;
    wr(A_AC, {11'b0, 1'b1, 1'b0, ch});
    chk("R6 ready low after start", adc_ready_o, 0);
    repeat (9) @(negedge clk);
    chk("R6 ready low at edge 9", adc_ready_o, 0);
    @(negedge clk);
    chk("R11 done with ready", {adc_ready_o, conv_done_o}, 2'b11);
    @(negedge clk);
    chk("R11 done single cycle", conv_done_o, 0);
    rd(A_DR, d);
    chk("R7 R8 result", d, {1'b1, 5'b0, val});
  endtask

  initial begin
    logic [15:0] d;
    int seen;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 8; i++) vin[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd_addr = A_DR;
    @(negedge clk);
    chk("R1 reset outputs", {plate_pwr_o, plate_gnd_o, bias_en_o, x_pullup_o,
         meas_mode_o, mux_sel_o, adc_ready_o, conv_done_o}, 0);
    chk("R1 reset read", rd_data, 0);

    // plate control: directed then random
    plate_case(11'b00_1_1111_1111, "R2 all conflict ground wins");
    plate_case(11'b01_1_0000_0101, "R3 pressure bias");
    plate_case(11'b10_0_1000_0011, "R3 resistance");
    plate_case(11'b11_1_0000_1111, "R4 detect");
    for (int i = 0; i < 20; i++) plate_case(11'($urandom), "R2 R3 R4 random");
    wr(A_TC, 16'h05a3);
    rd(A_TC, d);
    chk("R12 touch readback", d, 16'h05a3);

    // multiplexer select and readback
    for (int c = 0; c < 8; c++) begin
      wr(A_AC, {12'b0, 1'b0, 3'(c)});
      chk("R5 mux select", mux_sel_o, c);
    end
    wr(A_AC, 16'h001d);
    rd(A_AC, d);
    chk("R12 adc readback start reads 0", d, 16'h000d);
    chk("R9 arm leaves ready", adc_ready_o, 0);

    // direct conversions
    direct_conv(3'd0, 10'd0);
    direct_conv(3'd7, 10'h3ff);
    direct_conv(3'd2, 10'h200);
    direct_conv(3'd5, 10'h1ff);
    for (int i = 0; i < 8; i++) direct_conv(3'($urandom), 10'($urandom));

    // R10: start mid-run and on the final edge are ignored
    vin[4] = 10'h2c7;
    wr(A_AC, 16'h0014);
    repeat (3) @(negedge clk);
    wr(A_AC, 16'h0014);
    repeat (5) @(negedge clk);
    chk("R10 ready low at edge 9", adc_ready_o, 0);
    wr(A_AC, 16'h0014);
    chk("R10 finish on schedule", {adc_ready_o, conv_done_o}, 2'b11);
    @(negedge clk);
    chk("R10 no restart", {adc_ready_o, conv_done_o}, 2'b10);
    @(negedge clk);
    chk("R10 still idle", adc_ready_o, 1);
    rd(A_DR, d);
    chk("R10 result kept", d, {1'b1, 5'b0, 10'h2c7});

    // R9: armed sync start
    vin[6] = 10'h155;
    wr(A_AC, 16'h001e);
    repeat (5) @(negedge clk);
    chk("R9 armed no start", {adc_ready_o, conv_done_o}, 2'b10);
    adc_sync = 1'b1;
    seen = 0;
    for (int i = 0; i < 20 && seen == 0; i++) begin
      @(negedge clk);
      if (conv_done_o) seen = i + 1;
    end
    chk("R9 sync edge starts conversion", seen >= 12 && seen <= 14, 1);
    adc_sync = 1'b0;
    rd(A_DR, d);
    chk("R9 sync result", d, {1'b1, 5'b0, 10'h155});
    repeat (3) @(negedge clk);
    adc_sync = 1'b1;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!adc_ready_o || conv_done_o) seen = 1;
    end
    chk("R9 unarmed sync ignored", seen, 0);
    adc_sync = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule